// File: doc/BRIEF.md
# Down-Counting Periodic Interrupt Timer

This block is a 32-bit down-counter that raises a maskable level interrupt each time it expires. Software reaches it through a small word-addressed register bus. Through that bus it sets a control word, a load value and a compare value, and it reads back a status flag and the live count. Three tick-enable inputs are present, one for each clock source. The control word selects one of them, and a programmable divider slows the selected source by the prescale value plus one. Each divided step moves the counter down by one.

When a divided step arrives while the count is already zero, the counter expires and the status flag is set. The count then either reloads from the load register or wraps to all-ones, depending on a mode bit. A load write can also overwrite the running count at once. A write to the status word acknowledges the interrupt. A software reset bit in the control word returns the whole block to its reset state.

Top module: `ptmr_top`

## Requirements
- R1: Register word offsets on `reg_addr` are: 0 control, 1 status, 2 load, 3 compare, 4 count (read only). `reg_rdata` shows the addressed word combinationally. Any other offset reads as zero.
- R2: The control word stores bits 25:0 except bit 16. Writing 0xFFFEFFFF reads back 0x03FEFFFF. The bits used are: 0 enable, 1 enable mode (stored only), 2 interrupt enable, 3 reload mode, 15:4 prescale, 16 software reset, 17 immediate overwrite, 18 to 21 low-power bits (stored only), 25:24 source select.
- R3: The source select value picks the tick input: 1 selects `tick_a`, 2 selects `tick_b`, 3 selects `tick_c`. Only the selected tick advances the divider. A step occurs on every (prescale+1)-th selected tick.
- R4: The counter changes on steps only while enable (bit 0) is set and the source select is nonzero. Otherwise ticks leave the count unchanged.
- R5: A step taken while the count is zero is an expiry. An expiry sets the status flag. When reload mode (bit 3) is set, the count becomes the load value.
- R6: On an expiry with reload mode clear, the count becomes 0xFFFFFFFF.
- R7: Any write to the status word clears the flag. An expiry in the same cycle wins, and the flag ends up set. The status word reads the flag in bit 0.
- R8: `irq` equals the flag ANDed with interrupt enable (bit 2).
- R9: Hard reset, or a control write with bit 16 set, clears control, compare and the flag, sets load and count to 0xFFFFFFFF, and stops the counter. The rest of that written control value is discarded.
- R10: A load write while the immediate overwrite bit (17) is set also puts the written value into the count in the same cycle. Without bit 17, the count is untouched.
- R11: The compare word is read/write storage and has no effect on counting.
- R12: Every control write restarts the prescale divider from zero.
- R13: A step taken while the count is nonzero decrements the count by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the addressed word |
| reg_addr | input | 3 | Word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed word |
| tick_a | input | 1 | Tick enable for source 1 |
| tick_b | input | 1 | Tick enable for source 2 |
| tick_c | input | 1 | Tick enable for source 3 (slow tick) |
| irq | output | 1 | Level interrupt |

## Verification
The bench aims at the places where a counter like this usually goes wrong. One is the step taken at count zero. A design that decremented there would wrap silently, and one that flagged on the 1-to-0 step would fire one step early. Another is a status acknowledge that lands in the same cycle as an expiry: a design that let the clear win would lose an interrupt. The bench also checks that ticks from unselected sources, and ticks with source zero, are ignored. It checks that a control rewrite part-way through a prescale period restarts the divider, since a design without that restart would step early. Finally, it checks that the software reset returns load and count to all-ones instead of zero.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int DATA_W = 32;
  localparam int PRE_W  = 12;
  localparam int SRC_W  = 2;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_LOAD = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_CMP  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 3'd4;

  localparam int B_EN     = 0;
  localparam int B_IE     = 2;
  localparam int B_RELOAD = 3;
  localparam int B_PRE_LO = 4;
  localparam int B_SWR    = 16;
  localparam int B_OVW    = 17;
  localparam int B_SRC_LO = 24;

  localparam logic [DATA_W-1:0] CTRL_KEEP = 32'h03FE_FFFF;

  function automatic logic [DATA_W-1:0] count_after_step(
      input logic [DATA_W-1:0] cur, input logic [DATA_W-1:0] ld, input logic reload);
    if (cur != '0) return cur - 1'b1;
    else if (reload) return ld;
    else return '1;
  endfunction

  function automatic logic divider_wraps(input logic [PRE_W-1:0] cnt, input logic [PRE_W-1:0] lim);
    return cnt == lim;
  endfunction
endpackage

// File: rtl/ptmr_ctrl_regs.sv
module ptmr_ctrl_regs
  import ptmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_load,
  input  logic              wr_cmp,
  input  logic [DATA_W-1:0] wdata,
  output logic              soft_rst,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] load_q,
  output logic [DATA_W-1:0] cmp_q
);
  assign soft_rst = wr_ctrl & wdata[B_SWR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= '1;
      cmp_q  <= '0;
    end else if (soft_rst) begin
      ctrl_q <= '0;
      load_q <= '1;
      cmp_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata & CTRL_KEEP;
      if (wr_load) load_q <= wdata;
      if (wr_cmp)  cmp_q  <= wdata;
    end
  end
endmodule

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler
  import ptmr_pkg::*;
#(
  parameter int W = PRE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         step
);
  logic [W-1:0] div_q;
  logic         hit;

  assign hit  = divider_wraps(div_q, limit);
  assign step = run & tick & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            div_q <= '0;
    else if (restart)      div_q <= '0;
    else if (run && tick)  div_q <= hit ? '0 : div_q + 1'b1;
  end
endmodule

// File: rtl/ptmr_down_counter.sv
module ptmr_down_counter
  import ptmr_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic         ovw_load,
  input  logic [W-1:0] ovw_val,
  input  logic         step,
  input  logic         reload_mode,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         expire
);
  assign expire = step & (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '1;
    else if (soft_rst) count <= '1;
    else if (ovw_load) count <= ovw_val;
    else if (step)     count <= count_after_step(count, load_val, reload_mode);
  end
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
  import ptmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tick_a,
  input  logic              tick_b,
  input  logic              tick_c,
  output logic              irq
);
  localparam int NSRC = (1 << SRC_W) - 1;

  logic [DATA_W-1:0] ctrl_q, load_q, cmp_q, count;
  logic              wr_ctrl, wr_stat, wr_load, wr_cmp;
  logic              soft_rst, ovw_load, run, step, expire, flag, sel_tick;
  logic [SRC_W-1:0]  src;
  logic [NSRC:0]     tick_vec;

  assign wr_ctrl = reg_wr && reg_addr == OFS_CTRL;
  assign wr_stat = reg_wr && reg_addr == OFS_STAT;
  assign wr_load = reg_wr && reg_addr == OFS_LOAD;
  assign wr_cmp  = reg_wr && reg_addr == OFS_CMP;

  ptmr_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_load(wr_load), .wr_cmp(wr_cmp),
    .wdata(reg_wdata), .soft_rst(soft_rst), .ctrl_q(ctrl_q), .load_q(load_q), .cmp_q(cmp_q)
  );

  assign src = ctrl_q[B_SRC_LO +: SRC_W];
  assign run = ctrl_q[B_EN] && src != '0;

  genvar gi;
  assign tick_vec[0] = 1'b0;
  generate
    for (gi = 1; gi <= NSRC; gi++) begin : g_src
      if (gi == 1)      begin : g_a assign tick_vec[gi] = tick_a; end
      else if (gi == 2) begin : g_b assign tick_vec[gi] = tick_b; end
      else              begin : g_c assign tick_vec[gi] = tick_c; end
    end
  endgenerate
  assign sel_tick = tick_vec[src];

  ptmr_prescaler #(.W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(wr_ctrl), .run(run), .tick(sel_tick),
    .limit(ctrl_q[B_PRE_LO +: PRE_W]), .step(step)
  );

  assign ovw_load = wr_load & ctrl_q[B_OVW];

  ptmr_down_counter #(.W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ovw_load(ovw_load), .ovw_val(reg_wdata),
    .step(step), .reload_mode(ctrl_q[B_RELOAD]), .load_val(load_q),
    .count(count), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (soft_rst) flag <= 1'b0;
    else if (expire)   flag <= 1'b1;
    else if (wr_stat)  flag <= 1'b0;
  end

  assign irq = flag & ctrl_q[B_IE];

  always_comb begin
    case (reg_addr)
      OFS_CTRL: reg_rdata = ctrl_q;
      OFS_STAT: reg_rdata = {{(DATA_W-1){1'b0}}, flag};
      OFS_LOAD: reg_rdata = load_q;
      OFS_CMP:  reg_rdata = cmp_q;
      OFS_CNT:  reg_rdata = count;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker
  import ptmr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              step,
  input logic              expire,
  input logic              soft_rst,
  input logic              ovw_load,
  input logic              wr_stat,
  input logic              reload_mode,
  input logic              ie,
  input logic              flag,
  input logic              irq,
  input logic [DATA_W-1:0] count,
  input logic [DATA_W-1:0] load_q,
  input logic [DATA_W-1:0] wdata
);
  AST_STEP_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n) step |-> run); // R4
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ovw_load && !soft_rst) |=> count == $past(count)); // R4
  AST_EXPIRE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !soft_rst) |=> flag); // R5
  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && reload_mode && !ovw_load && !soft_rst) |=> count == $past(load_q)); // R5
  AST_ROLL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !reload_mode && !ovw_load && !soft_rst) |=> count == '1); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !expire) |=> !flag); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (ie && flag)); // R8
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (count == '1 && !flag)); // R9
  AST_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ovw_load && !soft_rst) |=> count == $past(wdata)); // R10
endmodule

bind ptmr_top ptmr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .step(step), .expire(expire), .soft_rst(soft_rst),
  .ovw_load(ovw_load), .wr_stat(wr_stat), .reload_mode(ctrl_q[B_RELOAD]), .ie(ctrl_q[B_IE]),
  .flag(flag), .irq(irq), .count(count), .load_q(load_q), .wdata(reg_wdata)
);

// File: tb/ptmr_top_test.sv
module ptmr_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tick_a = 1'b0, tick_b = 1'b0, tick_c = 1'b0;
  logic        irq;
  int          total = 0, bad = 0;
  bit          done = 0;

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  ptmr_top uut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_a(tick_a), .tick_b(tick_b),
    .tick_c(tick_c), .irq(irq));

  // monitor: samples well after the driving negedge, well before the next posedge
  initial forever begin
    @(negedge clk); #4;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = (it.kind == 8) ? {31'b0, irq} : reg_rdata;
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic chk(input int kind, input logic [31:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    if (kind < 8) reg_addr = kind[2:0];
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic tk(input int which, input int n);
    repeat (n) begin
      @(negedge clk);
      tick_a = (which == 1); tick_b = (which == 2); tick_c = (which == 3);
      @(negedge clk);
      tick_a = 1'b0; tick_b = 1'b0; tick_c = 1'b0;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state R1 R9
    chk(0, 32'h0, "R9 reset ctrl");
    chk(1, 32'h0, "R9 reset status");
    chk(2, 32'hFFFF_FFFF, "R9 reset load");
    chk(3, 32'h0, "R9 reset cmp");
    chk(4, 32'hFFFF_FFFF, "R9 reset count");
    chk(8, 32'h0, "R8 reset irq");
    chk(5, 32'h0, "R1 unmapped offset");
    // R2 storage mask
    wr(0, 32'hFFFE_FFFF);
    chk(0, 32'h03FE_FFFF, "R2 ctrl mask");
    wr(0, 32'h0);
    // R11 compare storage
    wr(3, 32'd5);
    chk(3, 32'd5, "R11 cmp readback");
    chk(4, 32'hFFFF_FFFF, "R11 cmp no effect");
    // R10 overwrite
    wr(2, 32'd10);
    chk(2, 32'd10, "R10 load stored");
    chk(4, 32'hFFFF_FFFF, "R10 no overwrite without bit17");
    wr(0, 32'h0002_0000);
    wr(2, 32'd3);
    chk(4, 32'd3, "R10 immediate overwrite");
    // R4 halted cases
    wr(0, 32'h0002_0001);
    tk(1, 2); tk(2, 1); tk(3, 1);
    chk(4, 32'd3, "R4 source zero halts");
    wr(0, 32'h0102_0000);
    tk(1, 2);
    chk(4, 32'd3, "R4 enable clear halts");
    // R13 R3 stepping, src1, reload+ie
    wr(0, 32'h0102_000D);
    tk(1, 1);
    chk(4, 32'd2, "R13 decrement");
    tk(2, 1);
    chk(4, 32'd2, "R3 unselected source ignored");
    tk(1, 2);
    chk(4, 32'd0, "R13 reach zero");
    chk(1, 32'd0, "R5 no flag at zero");
    tk(1, 1);
    chk(4, 32'd3, "R5 reload on expiry");
    chk(1, 32'd1, "R5 flag set");
    chk(8, 32'd1, "R8 irq raised");
    wr(0, 32'h0102_0009);
    chk(8, 32'd0, "R8 irq masked");
    chk(1, 32'd1, "R8 flag kept while masked");
    wr(1, 32'd0);
    chk(1, 32'd0, "R7 status write clears");
    // R6 roll to all-ones
    wr(0, 32'h0100_0001);
    tk(1, 3);
    chk(4, 32'd0, "R6 count down to zero");
    tk(1, 1);
    chk(4, 32'hFFFF_FFFF, "R6 roll to ones");
    chk(1, 32'd1, "R6 flag set");
    wr(1, 32'hFFFF_FFFF);
    // R3 prescale by 3 on src3
    wr(0, 32'h0300_0021);
    tk(1, 1);
    chk(4, 32'hFFFF_FFFF, "R3 src1 ignored when src3");
    tk(3, 2);
    chk(4, 32'hFFFF_FFFF, "R3 prescale holds");
    tk(3, 1);
    chk(4, 32'hFFFF_FFFE, "R3 prescale step");
    // R12 divider restart
    tk(3, 2);
    wr(0, 32'h0300_0021);
    tk(3, 2);
    chk(4, 32'hFFFF_FFFE, "R12 restart delays step");
    tk(3, 1);
    chk(4, 32'hFFFF_FFFD, "R12 step after restart");
    // R7 collision: expiry beats acknowledge
    wr(0, 32'h0102_000D);
    wr(2, 32'd0);
    chk(4, 32'd0, "R10 overwrite to zero");
    chk(1, 32'd0, "R7 flag clear before collision");
    @(negedge clk); reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 32'd1; tick_a = 1'b1;
    @(negedge clk); reg_wr = 1'b0; tick_a = 1'b0;
    chk(1, 32'd1, "R7 expiry wins over ack");
    // R9 software reset
    wr(3, 32'd7);
    wr(0, 32'h0001_0FFF);
    chk(0, 32'h0, "R9 swr ctrl");
    chk(1, 32'h0, "R9 swr status");
    chk(2, 32'hFFFF_FFFF, "R9 swr load");
    chk(3, 32'h0, "R9 swr cmp");
    chk(4, 32'hFFFF_FFFF, "R9 swr count");
    chk(8, 32'h0, "R9 swr irq");
    tk(1, 2);
    chk(4, 32'hFFFF_FFFF, "R9 stopped after swr");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule